// File: doc/BRIEF.md
# Multi-Pool LIFO Token Allocator

This block holds many independent pools of opaque buffer tokens and hands them out on request. A client presents one command per cycle through a valid/ready handshake: a release pushes a token into the named pool, and an acquire pops the token most recently pushed there. Tokens are never interpreted; any bit pattern returns unchanged. Each command gets exactly one response, in the cycle after it is accepted, so responses keep command order.

Each pool keeps a small circular stockpile of tokens in registers. Behind it sits a larger per-pool backing stack. A sequencer spills tokens from the bottom of a stockpile into the backing stack when occupancy rises above a high mark. It refills the stockpile from the backing stack when occupancy falls below a low mark. Each burst ends once occupancy reaches the middle of the band. Spilling and filling only use cycles in which no client command is accepted. Each pool also carries a programmable depletion threshold and a sticky interrupt flag.

Top module: `multipool_lifo_alloc`

## Requirements
- R1: An acquire on a pool returns the token most recently released to that same pool and not yet acquired; pools do not affect one another.
- R2: Token values are carried unaltered, including all-zeros and all-ones.
- R3: An acquire on a pool that holds no token anywhere responds with rsp_fail=1 and rsp_token=0, and leaves the pool's contents unchanged.
- R4: A release to a pool whose stockpile and backing stack are both full responds with rsp_ovf=1, and the token is discarded.
- R5: When the stockpile occupancy exceeds HI_MARK, tokens spill from the stockpile bottom into the backing stack. When it drops below LO_MARK, tokens are refilled from the backing stack. Both directions preserve the pool's overall last-in-first-out order.
- R6: Every accepted command produces rsp_valid=1 in the next cycle, with rsp_op equal to the command's op (0 = acquire, 1 = release).
- R7: A pool's depl_irq bit sets when the pool's total free count (stockpile plus backing) is below its threshold and the pool is armed. Thresholds reset to 0, which never triggers.
- R8: Writing 1 to a pool's irq_clr bit clears its depl_irq bit. The bit cannot set again until the free count has risen above the threshold.
- R9: cmd_ready is low while the commanded pool has a spill or fill burst in progress. A command to a different pool is accepted without stalling.
- R10: After reset, cmd_ready=1, rsp_valid=0 and depl_irq is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 1 | 0 = acquire, 1 = release |
| cmd_pool | input | clog2(N_POOLS) | Target pool |
| cmd_token | input | TOK_W | Token for a release |
| rsp_valid | output | 1 | Response present |
| rsp_op | output | 1 | Op of the answered command |
| rsp_token | output | TOK_W | Acquired token, 0 otherwise |
| rsp_fail | output | 1 | Acquire found the pool empty |
| rsp_ovf | output | 1 | Release found the pool full; token dropped |
| thr_we | input | 1 | Threshold write strobe |
| thr_pool | input | clog2(N_POOLS) | Pool whose threshold is written |
| thr_value | input | clog2(STK_DEPTH+BACK_DEPTH+1) | New threshold |
| irq_clr | input | N_POOLS | Write-one-to-clear per pool |
| depl_irq | output | N_POOLS | Sticky depletion flags |

## Verification
The bench builds the block with 4 pools, an 8-entry stockpile, an 8-entry backing stack, a low mark of 2 and a high mark of 6. With these values a burst of seven releases triggers a spill that the bench can stall against. Sixteen releases fill a pool completely, so overflow, refill on drain and empty-pool failure can all be reached within a few hundred cycles. A threshold of 3 lets the sticky flag, its clear and its re-arm condition be exercised with a handful of tokens.

// File: rtl/lifo_alloc_pkg.sv
package lifo_alloc_pkg;
  typedef enum logic {OP_ACQ = 1'b0, OP_REL = 1'b1} op_e;

  function automatic int unsigned free_total(input int unsigned stk, input int unsigned bak);
    return stk + bak;
  endfunction

  function automatic logic is_below(input int unsigned freec, input int unsigned thr);
    return freec < thr;
  endfunction

  function automatic int unsigned band_mid(input int unsigned lo, input int unsigned hi);
    return (lo + hi) / 2;
  endfunction
endpackage

// File: rtl/lifo_pool.sv
module lifo_pool
  import lifo_alloc_pkg::*;
#(
  parameter int TOK_W      = 32,
  parameter int STK_DEPTH  = 16,
  parameter int BACK_DEPTH = 64,
  parameter int SCW        = $clog2(STK_DEPTH) + 1,
  parameter int BCW        = $clog2(BACK_DEPTH) + 1,
  parameter int CW         = $clog2(STK_DEPTH + BACK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             spill,
  input  logic             fill,
  input  logic [TOK_W-1:0] push_tok,
  input  logic             thr_we,
  input  logic [CW-1:0]    thr_val,
  input  logic             irq_clr,
  output logic [TOK_W-1:0] top_tok,
  output logic [SCW-1:0]   scnt,
  output logic [BCW-1:0]   bcnt,
  output logic             irq
);
  localparam int SAW = $clog2(STK_DEPTH);
  localparam int BAW = $clog2(BACK_DEPTH);

  logic [TOK_W-1:0] stk [STK_DEPTH];
  logic [TOK_W-1:0] bk  [BACK_DEPTH];
  logic [SAW-1:0]   base;
  logic [SAW-1:0]   top_idx, wr_idx, fill_idx;
  logic [BAW-1:0]   bk_top, bk_wr;
  logic [CW-1:0]    thr, free_c;
  logic             armed, below, above;

  assign top_idx  = base + SAW'(scnt) - SAW'(1);
  assign wr_idx   = base + SAW'(scnt);
  assign fill_idx = base - SAW'(1);
  assign bk_top   = BAW'(bcnt - BCW'(1));
  assign bk_wr    = BAW'(bcnt);
  assign top_tok  = stk[top_idx];

  assign free_c = CW'(free_total(int'(scnt), int'(bcnt)));
  assign below  = is_below(int'(free_c), int'(thr));
  assign above  = int'(free_c) > int'(thr);

  always_ff @(posedge clk) begin
    if (push)      stk[wr_idx]   <= push_tok;
    else if (fill) stk[fill_idx] <= bk[bk_top];
    if (spill)     bk[bk_wr]     <= stk[base];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      scnt <= '0;
      bcnt <= '0;
    end else if (push) begin
      scnt <= scnt + SCW'(1);
    end else if (pop) begin
      scnt <= scnt - SCW'(1);
    end else if (spill) begin
      base <= base + SAW'(1);
      scnt <= scnt - SCW'(1);
      bcnt <= bcnt + BCW'(1);
    end else if (fill) begin
      base <= base - SAW'(1);
      scnt <= scnt + SCW'(1);
      bcnt <= bcnt - BCW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr   <= '0;
      armed <= 1'b1;
      irq   <= 1'b0;
    end else begin
      if (thr_we) thr <= thr_val;
      if (irq_clr) irq <= 1'b0;
      if (armed && below) begin
        irq   <= 1'b1;
        armed <= 1'b0;
      end else if (!armed && above) begin
        armed <= 1'b1;
      end
    end
  end

  a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> scnt != '0);
  a_r4_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> scnt != SCW'(STK_DEPTH));
  a_r5_spill_room: assert property (@(posedge clk) disable iff (!rst_n)
    spill |-> bcnt != BCW'(BACK_DEPTH));
  a_r5_fill_source: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> bcnt != '0);
  a_r7_rise_when_below: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(below));
endmodule

// File: rtl/lifo_seq.sv
module lifo_seq
  import lifo_alloc_pkg::*;
#(
  parameter int N_POOLS    = 8,
  parameter int STK_DEPTH  = 16,
  parameter int BACK_DEPTH = 64,
  parameter int LO_MARK    = 4,
  parameter int HI_MARK    = 12,
  parameter int PW         = $clog2(N_POOLS),
  parameter int SCW        = $clog2(STK_DEPTH) + 1,
  parameter int BCW        = $clog2(BACK_DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SCW-1:0]     scnt [N_POOLS],
  input  logic [BCW-1:0]     bcnt [N_POOLS],
  input  logic               cmd_taken,
  output logic               busy,
  output logic [PW-1:0]      cur_pool,
  output logic [N_POOLS-1:0] spill_en,
  output logic [N_POOLS-1:0] fill_en
);
  localparam int MID = int'(band_mid(LO_MARK, HI_MARK));

  logic [N_POOLS-1:0] need_sp, need_fl;
  logic               found, pick_dir, dir, done_now, step;
  logic [PW-1:0]      pick;

  for (genvar g = 0; g < N_POOLS; g++) begin : g_need
    assign need_sp[g] = int'(scnt[g]) > HI_MARK && int'(bcnt[g]) < BACK_DEPTH;
    assign need_fl[g] = int'(scnt[g]) < LO_MARK && bcnt[g] != '0;
  end

  always_comb begin
    found    = 1'b0;
    pick     = '0;
    pick_dir = 1'b0;
    for (int i = N_POOLS - 1; i >= 0; i--) begin
      if (need_sp[i] || need_fl[i]) begin
        found    = 1'b1;
        pick     = PW'(i);
        pick_dir = need_sp[i];
      end
    end
  end

  assign done_now = dir ? (int'(scnt[cur_pool]) <= MID || int'(bcnt[cur_pool]) == BACK_DEPTH)
                        : (int'(scnt[cur_pool]) >= MID || bcnt[cur_pool] == '0);
  assign step = busy && !done_now && !cmd_taken;

  always_comb begin
    spill_en = '0;
    fill_en  = '0;
    if (step) begin
      if (dir) spill_en[cur_pool] = 1'b1;
      else     fill_en[cur_pool]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_pool <= '0;
      dir      <= 1'b0;
    end else if (!busy && found) begin
      busy     <= 1'b1;
      cur_pool <= pick;
      dir      <= pick_dir;
    end else if (busy && done_now) begin
      busy <= 1'b0;
    end
  end

  a_r9_steps_yield: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_taken |-> (spill_en == '0 && fill_en == '0));
  a_r5_pool_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_pool));
endmodule

// File: rtl/multipool_lifo_alloc.sv
module multipool_lifo_alloc
  import lifo_alloc_pkg::*;
#(
  parameter int N_POOLS    = 8,
  parameter int TOK_W      = 32,
  parameter int STK_DEPTH  = 16,
  parameter int BACK_DEPTH = 64,
  parameter int LO_MARK    = 4,
  parameter int HI_MARK    = 12
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       cmd_valid,
  output logic                                       cmd_ready,
  input  logic                                       cmd_op,
  input  logic [$clog2(N_POOLS)-1:0]                 cmd_pool,
  input  logic [TOK_W-1:0]                           cmd_token,
  output logic                                       rsp_valid,
  output logic                                       rsp_op,
  output logic [TOK_W-1:0]                           rsp_token,
  output logic                                       rsp_fail,
  output logic                                       rsp_ovf,
  input  logic                                       thr_we,
  input  logic [$clog2(N_POOLS)-1:0]                 thr_pool,
  input  logic [$clog2(STK_DEPTH+BACK_DEPTH+1)-1:0]  thr_value,
  input  logic [N_POOLS-1:0]                         irq_clr,
  output logic [N_POOLS-1:0]                         depl_irq
);
  localparam int PW  = $clog2(N_POOLS);
  localparam int SCW = $clog2(STK_DEPTH) + 1;
  localparam int BCW = $clog2(BACK_DEPTH) + 1;
  localparam int CW  = $clog2(STK_DEPTH + BACK_DEPTH + 1);

  logic [SCW-1:0]     scnt    [N_POOLS];
  logic [BCW-1:0]     bcnt    [N_POOLS];
  logic [TOK_W-1:0]   top_tok [N_POOLS];
  logic [N_POOLS-1:0] push_v, pop_v, spill_en, fill_en;
  logic               seq_busy;
  logic [PW-1:0]      seq_pool;
  logic               is_rel, stk_full, bk_full, stk_empty, bk_empty;
  logic               pool_busy, blocked, accept, do_push, do_pop;

  assign is_rel    = (cmd_op == OP_REL);
  assign stk_full  = scnt[cmd_pool] == SCW'(STK_DEPTH);
  assign bk_full   = bcnt[cmd_pool] == BCW'(BACK_DEPTH);
  assign stk_empty = scnt[cmd_pool] == '0;
  assign bk_empty  = bcnt[cmd_pool] == '0;
  assign pool_busy = seq_busy && (seq_pool == cmd_pool);
  assign blocked   = pool_busy
                   || (is_rel && stk_full && !bk_full)
                   || (!is_rel && stk_empty && !bk_empty);
  assign cmd_ready = !blocked;
  assign accept    = cmd_valid && cmd_ready;
  assign do_push   = accept && is_rel && !stk_full;
  assign do_pop    = accept && !is_rel && !stk_empty;

  for (genvar g = 0; g < N_POOLS; g++) begin : g_pool
    assign push_v[g] = do_push && (cmd_pool == PW'(g));
    assign pop_v[g]  = do_pop && (cmd_pool == PW'(g));

    lifo_pool #(
      .TOK_W(TOK_W), .STK_DEPTH(STK_DEPTH), .BACK_DEPTH(BACK_DEPTH),
      .SCW(SCW), .BCW(BCW), .CW(CW)
    ) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push_v[g]),
      .pop      (pop_v[g]),
      .spill    (spill_en[g]),
      .fill     (fill_en[g]),
      .push_tok (cmd_token),
      .thr_we   (thr_we && (thr_pool == PW'(g))),
      .thr_val  (thr_value),
      .irq_clr  (irq_clr[g]),
      .top_tok  (top_tok[g]),
      .scnt     (scnt[g]),
      .bcnt     (bcnt[g]),
      .irq      (depl_irq[g])
    );
  end

  lifo_seq #(
    .N_POOLS(N_POOLS), .STK_DEPTH(STK_DEPTH), .BACK_DEPTH(BACK_DEPTH),
    .LO_MARK(LO_MARK), .HI_MARK(HI_MARK), .PW(PW), .SCW(SCW), .BCW(BCW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .scnt      (scnt),
    .bcnt      (bcnt),
    .cmd_taken (accept),
    .busy      (seq_busy),
    .cur_pool  (seq_pool),
    .spill_en  (spill_en),
    .fill_en   (fill_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_op    <= 1'b0;
      rsp_token <= '0;
      rsp_fail  <= 1'b0;
      rsp_ovf   <= 1'b0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_op    <= cmd_op;
        rsp_token <= do_pop ? top_tok[cmd_pool] : '0;
        rsp_fail  <= !is_rel && stk_empty;
        rsp_ovf   <= is_rel && stk_full;
      end
    end
  end

  a_r6_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rsp_valid && rsp_op == $past(cmd_op)));
  a_r9_no_busy_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !(seq_busy && seq_pool == cmd_pool));
  a_r3_fail_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fail) |-> (rsp_token == '0 && rsp_op == OP_ACQ));
  a_r4_ovf_is_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ovf) |-> rsp_op == OP_REL);
endmodule

// File: tb/test_multipool_lifo_alloc.sv
`timescale 1ns/1ps
module test_multipool_lifo_alloc;
  localparam int NP = 4, TW = 32, SD = 8, BD = 8, LO = 2, HI = 6;
  localparam int PW = $clog2(NP);
  localparam int CW = $clog2(SD + BD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [PW-1:0] cmd_pool = '0, thr_pool = '0;
  logic [TW-1:0] cmd_token = '0;
  logic cmd_ready, rsp_valid, rsp_op, rsp_fail, rsp_ovf;
  logic [TW-1:0] rsp_token;
  logic thr_we = 1'b0;
  logic [CW-1:0] thr_value = '0;
  logic [NP-1:0] irq_clr = '0, depl_irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic g_valid, g_op, g_fail, g_ovf;
  logic [TW-1:0] g_tok;
  int g_stall;

  always #10 clk = ~clk;

  multipool_lifo_alloc #(.N_POOLS(NP), .TOK_W(TW), .STK_DEPTH(SD), .BACK_DEPTH(BD),
    .LO_MARK(LO), .HI_MARK(HI)) i_multipool_lifo_alloc (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pool(cmd_pool), .cmd_token(cmd_token),
    .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_token(rsp_token),
    .rsp_fail(rsp_fail), .rsp_ovf(rsp_ovf), .thr_we(thr_we), .thr_pool(thr_pool),
    .thr_value(thr_value), .irq_clr(irq_clr), .depl_irq(depl_irq));

  task automatic check(input bit ok, input string req, input logic [TW-1:0] act,
                       input logic [TW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic op, input int pool, input logic [TW-1:0] tok);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pool = PW'(pool); cmd_token = tok;
    g_stall = 0;
    #1;
    while (!cmd_ready) begin
      @(negedge clk); #1;
      g_stall++;
    end
    @(negedge clk);
    g_valid = rsp_valid; g_op = rsp_op; g_tok = rsp_token;
    g_fail = rsp_fail; g_ovf = rsp_ovf;
    cmd_valid = 1'b0;
  endtask

  task automatic acq_expect(input int pool, input logic [TW-1:0] exp, input string req);
    cmd(1'b0, pool, '0);
    check(g_valid && !g_fail && g_tok == exp, req, g_tok, exp);
  endtask

  task automatic t_reset();
    check(cmd_ready == 1'b1, "R10 ready", TW'(cmd_ready), 1);
    check(rsp_valid == 1'b0, "R10 rsp_valid", TW'(rsp_valid), 0);
    check(depl_irq == '0, "R10 irq", TW'(depl_irq), 0);
  endtask

  task automatic t_lifo();
    cmd(1'b1, 0, 32'hA1);
    check(g_valid && g_op == 1'b1 && !g_ovf, "R6 release response", TW'({g_valid, g_op}), 3);
    cmd(1'b1, 0, 32'hA2);
    cmd(1'b1, 0, 32'hA3);
    cmd(1'b1, 1, 32'hD1);
    acq_expect(0, 32'hA3, "R1 pool0 top");
    check(g_op == 1'b0, "R6 acquire op echo", TW'(g_op), 0);
    acq_expect(1, 32'hD1, "R1 pool1 independent");
    acq_expect(0, 32'hA2, "R1 pool0 second");
    acq_expect(0, 32'hA1, "R1 pool0 third");
  endtask

  task automatic t_opaque();
    cmd(1'b1, 1, 32'h0);
    cmd(1'b1, 1, 32'hFFFF_FFFF);
    acq_expect(1, 32'hFFFF_FFFF, "R2 all ones");
    acq_expect(1, 32'h0, "R2 all zeros");
  endtask

  task automatic t_empty();
    cmd(1'b0, 1, '0);
    check(g_valid && g_fail && g_tok == '0, "R3 empty fail", g_tok, 0);
    cmd(1'b1, 1, 32'h5A);
    acq_expect(1, 32'h5A, "R3 count unchanged after fail");
    cmd(1'b0, 1, '0);
    check(g_fail == 1'b1, "R3 empty again", TW'(g_fail), 1);
  endtask

  task automatic t_stall();
    for (int i = 0; i < 7; i++) cmd(1'b1, 0, TW'(32'h100 + i));
    cmd(1'b0, 0, '0);
    check(g_stall > 0, "R9 stall on busy pool", TW'(g_stall), 1);
    check(g_tok == 32'h106, "R1 token after stall", g_tok, 32'h106);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 4; i++) cmd(1'b1, 0, TW'(32'h200 + i));
    cmd(1'b1, 1, 32'h77);
    check(g_stall == 0 && g_valid, "R9 other pool accepted", TW'(g_stall), 0);
    for (int i = 3; i >= 0; i--) acq_expect(0, TW'(32'h200 + i), "R5 drain upper");
    for (int i = 5; i >= 0; i--) acq_expect(0, TW'(32'h100 + i), "R5 drain after spill");
    cmd(1'b0, 0, '0);
    check(g_fail == 1'b1, "R3 pool0 drained", TW'(g_fail), 1);
    acq_expect(1, 32'h77, "R1 pool1 token");
  endtask

  task automatic t_full();
    for (int i = 0; i < SD + BD; i++) begin
      cmd(1'b1, 2, TW'(32'h300 + i));
      check(!g_ovf, "R4 no early overflow", TW'(g_ovf), 0);
    end
    cmd(1'b1, 2, 32'hBAD);
    check(g_valid && g_ovf, "R4 overflow flagged", TW'(g_ovf), 1);
    for (int i = SD + BD - 1; i >= 0; i--) acq_expect(2, TW'(32'h300 + i), "R5 refill order");
    cmd(1'b0, 2, '0);
    check(g_fail == 1'b1, "R4 dropped token absent", g_tok, 0);
  endtask

  task automatic t_irq();
    @(negedge clk);
    thr_we = 1'b1; thr_pool = PW'(3); thr_value = CW'(3);
    @(negedge clk);
    thr_we = 1'b0;
    repeat (2) @(negedge clk);
    check(depl_irq[3] == 1'b1, "R7 set below threshold", TW'(depl_irq), 8);
    check(depl_irq[0] == 1'b0, "R7 zero threshold quiet", TW'(depl_irq), 8);
    irq_clr = 4'b1000;
    @(negedge clk);
    irq_clr = '0;
    repeat (3) @(negedge clk);
    check(depl_irq[3] == 1'b0, "R8 cleared stays clear", TW'(depl_irq), 0);
    for (int i = 0; i < 4; i++) cmd(1'b1, 3, TW'(32'h400 + i));
    repeat (2) @(negedge clk);
    check(depl_irq[3] == 1'b0, "R7 above threshold quiet", TW'(depl_irq), 0);
    cmd(1'b0, 3, '0);
    cmd(1'b0, 3, '0);
    repeat (2) @(negedge clk);
    check(depl_irq[3] == 1'b1, "R8 re-armed and set", TW'(depl_irq), 8);
    irq_clr = 4'b1000;
    @(negedge clk);
    irq_clr = '0;
    repeat (3) @(negedge clk);
    check(depl_irq[3] == 1'b0, "R8 second clear holds", TW'(depl_irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_lifo();
    t_opaque();
    t_empty();
    t_stall();
    t_full();
    t_irq();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule